// File: doc/BRIEF.md
# Brown-out Reset Release Sequencer

This block takes the asynchronous output of a supply brown-out detector and turns it into a held, active-high core reset together with a clock-enable that gates the system clock. Once the detector drops, the reset is not released at once. Three conditions are tracked at the same time. The first is an oscillator start-up count, which applies only when a crystal primary oscillator is configured. The second is the PLL lock indication, which applies only when the configured clock source uses the PLL. The third is a configurable power-up delay. The reset is released only when all three conditions are met.

If the power-up delay is configured to zero while a crystal source is selected, a fixed fail-safe delay takes its place. A sticky status flag records that a brown-out happened. Software clears it by writing 0, and a hardware set wins over a simultaneous clear. The clock-source selection in force is captured from the configuration inputs while the brown-out reset is held. The detection path has no low-power gating, so it works the same in every power mode. The block has no data stream, so every pin is plain control or status.

Configuration encodings:
- `cfg_osc_sel`:
  - 000 internal RC.
  - 001 internal RC with PLL.
  - 010 primary oscillator.
  - 011 primary oscillator with PLL.
  - 1xx low-power internal RC, with no PLL.
- `cfg_posc_mode`:
  - 00 external clock.
  - 01 low-speed crystal.
  - 10 high-speed crystal.
  - 11 primary off.
- A crystal source means a primary selection (01x) with mode 01 or 10.
- `cfg_pwrt` value k selects a power-up delay of PWRT_UNIT·2^(k-1) cycles, and k=0 means no power-up delay.
- Defaults: OST_CYCLES=8, PWRT_UNIT=4, FSCM_CYCLES=12.

Top module: `bor_release_seq`

## Requirements
- R1: After `bo_async` goes high, `core_rst` reads 1 and `clk_en` reads 0 from the 3rd rising edge on, and still read 0 and 1 after the 2nd. Both remain so while `bo_async` stays high.
- R2: With no crystal, no PLL and `cfg_pwrt`=0, `core_rst` falls on the 4th rising edge after `bo_async` falls, and `clk_en` reads 1 afterwards.
- R3: With a crystal source, the reset is held for at least OST_CYCLES. `core_rst` falls on edge L+4 after `bo_async` falls, where L is the larger of OST_CYCLES and the power-up delay.
- R4: When the PLL is in use, the reset is held and `clk_en` stays 0 until `pll_lock` is 1. `clk_en` rises 2 edges after `pll_lock` rises, and `core_rst` falls 3 edges after.
- R5: With `cfg_pwrt`=k>0, the release edge is PWRT_UNIT·2^(k-1)+4 after `bo_async` falls, unless the crystal count is longer.
- R6: With `cfg_pwrt`=0 and a crystal source, the release edge is FSCM_CYCLES+4 after `bo_async` falls.
- R7: A brown-out that arrives while waiting for release restarts all delays from zero, counted from its own fall.
- R8: `bor_flag` is set by a brown-out. A write with `sw_wdata`=0 clears it one edge later, and a write with `sw_wdata`=1 leaves it unchanged. A set during a brown-out wins over a clear.
- R9: `rel_pulse` is 1 for exactly the one cycle that begins on the edge where `core_rst` falls.
- R10: `clk_src` takes the value of `cfg_osc_sel` while the brown-out reset is held. Changes to `cfg_osc_sel` after release do not alter it.
- R11: After `rst_n`, `core_rst`=0, `clk_en`=1, `rel_pulse`=0, `bor_flag`=0 and `clk_src`=000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bo_async | input | 1 | Asynchronous brown-out detect, high while the supply is low |
| pll_lock | input | 1 | Asynchronous PLL lock indication |
| cfg_osc_sel | input | 3 | Clock source selection |
| cfg_posc_mode | input | 2 | Primary oscillator mode |
| cfg_pwrt | input | 3 | Power-up delay selection, 0 means none |
| sw_wr | input | 1 | Software write strobe for the status flag |
| sw_wdata | input | 1 | Value written to the status flag (only 0 acts) |
| core_rst | output | 1 | Active-high core reset |
| clk_en | output | 1 | System clock enable |
| rel_pulse | output | 1 | One-cycle pulse on reset release |
| bor_flag | output | 1 | Sticky brown-out status flag |
| clk_src | output | 3 | Clock source captured during the brown-out |

## Verification
The onset of a brown-out reaches `core_rst` on the 3rd rising edge, and a release is due on edge L+4 after the detector falls, where L is the longest active delay. A PLL lock reaches `clk_en` on edge 2 and `core_rst` on edge 3, and a flag write takes effect on edge 1. The bench drives every input on a falling edge and counts rising edges from that point. It samples on the following falling edge, checking the edge just before each due point and then the due edge itself. The release vector table holds each expected release edge, worked out by hand from the encodings above.

// File: rtl/bors_pkg.sv
package bors_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  localparam logic [1:0] POSC_EXT  = 2'b00;
  localparam logic [1:0] POSC_XTL  = 2'b01;
  localparam logic [1:0] POSC_XTH  = 2'b10;
  localparam logic [1:0] POSC_OFF  = 2'b11;

  localparam logic [1:0] SEL_PRIMARY_HI = 2'b01;

endpackage

// File: rtl/bors_sync.sv
module bors_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bors_timer.sv
module bors_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] len,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = (cnt >= len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (run && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bors_cfg_decode.sv
module bors_cfg_decode
  import bors_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int PWRT_UNIT   = 4,
  parameter int FSCM_CYCLES = 12
) (
  input  logic [2:0]       osc_sel,
  input  logic [1:0]       posc_mode,
  input  logic [2:0]       pwrt_sel,
  output logic             ost_req,
  output logic             pll_req,
  output logic [CNT_W-1:0] pwr_len
);
  logic primary;
  logic crystal;

  always_comb begin
    primary = (osc_sel[2:1] == SEL_PRIMARY_HI);
    crystal = primary && ((posc_mode == POSC_XTL) || (posc_mode == POSC_XTH));
    ost_req = crystal;
    pll_req = !osc_sel[2] && osc_sel[0];
    if (pwrt_sel == 3'd0) begin
      pwr_len = crystal ? CNT_W'(FSCM_CYCLES) : '0;
    end else begin
      pwr_len = CNT_W'(PWRT_UNIT) << (pwrt_sel - 3'd1);
    end
  end
endmodule

// File: rtl/bors_status.sv
module bors_status (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic wr,
  input  logic wdata,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag <= 1'b0;
    else if (hw_set)         flag <= 1'b1;
    else if (wr && !wdata)   flag <= 1'b0;
  end
endmodule

// File: rtl/bor_release_seq.sv
module bor_release_seq
  import bors_pkg::*;
#(
  parameter int OST_CYCLES  = 8,
  parameter int PWRT_UNIT   = 4,
  parameter int FSCM_CYCLES = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bo_async,
  input  logic       pll_lock,
  input  logic [2:0] cfg_osc_sel,
  input  logic [1:0] cfg_posc_mode,
  input  logic [2:0] cfg_pwrt,
  input  logic       sw_wr,
  input  logic       sw_wdata,
  output logic       core_rst,
  output logic       clk_en,
  output logic       rel_pulse,
  output logic       bor_flag,
  output logic [2:0] clk_src
);
  localparam int PWRT_MAX = PWRT_UNIT << 6;
  localparam int MAX_A    = (OST_CYCLES > FSCM_CYCLES) ? OST_CYCLES : FSCM_CYCLES;
  localparam int MAXLEN   = (MAX_A > PWRT_MAX) ? MAX_A : PWRT_MAX;
  localparam int CNT_W    = $clog2(MAXLEN + 1);
  localparam int N_SYNC   = 2;

  logic [N_SYNC-1:0] async_in;
  logic [N_SYNC-1:0] sync_out;
  logic              bo_s;
  logic              lock_s;

  assign async_in = {pll_lock, bo_async};

  for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
    bors_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (async_in[i]),
      .q     (sync_out[i])
    );
  end

  assign bo_s   = sync_out[0];
  assign lock_s = sync_out[1];

  logic             ost_req;
  logic             pll_req;
  logic [CNT_W-1:0] pwr_len;

  bors_cfg_decode #(
    .CNT_W       (CNT_W),
    .PWRT_UNIT   (PWRT_UNIT),
    .FSCM_CYCLES (FSCM_CYCLES)
  ) u_dec (
    .osc_sel   (cfg_osc_sel),
    .posc_mode (cfg_posc_mode),
    .pwrt_sel  (cfg_pwrt),
    .ost_req   (ost_req),
    .pll_req   (pll_req),
    .pwr_len   (pwr_len)
  );

  seq_state_e state, state_nx;
  logic       tmr_clr;
  logic       tmr_run;
  logic       ost_done;
  logic       pwr_done;
  logic       clk_ready;
  logic       release_now;

  assign tmr_clr = (state != ST_WAIT);
  assign tmr_run = (state == ST_WAIT);

  bors_timer #(.W(CNT_W)) u_ost (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .run   (tmr_run),
    .len   (CNT_W'(OST_CYCLES)),
    .done  (ost_done)
  );

  bors_timer #(.W(CNT_W)) u_pwr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .run   (tmr_run),
    .len   (pwr_len),
    .done  (pwr_done)
  );

  assign clk_ready   = (!ost_req || ost_done) && (!pll_req || lock_s);
  assign release_now = (state == ST_WAIT) && !bo_s && clk_ready && pwr_done;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:  if (bo_s) state_nx = ST_HOLD;
      ST_HOLD: if (!bo_s) state_nx = ST_WAIT;
      ST_WAIT: begin
        if (bo_s)             state_nx = ST_HOLD;
        else if (release_now) state_nx = ST_RUN;
      end
      default: state_nx = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      rel_pulse <= 1'b0;
      clk_src   <= 3'b000;
    end else begin
      state     <= state_nx;
      rel_pulse <= release_now;
      if (state == ST_HOLD) clk_src <= cfg_osc_sel;
    end
  end

  bors_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_set (bo_s),
    .wr     (sw_wr),
    .wdata  (sw_wdata),
    .flag   (bor_flag)
  );

  assign core_rst = (state != ST_RUN);
  assign clk_en   = (state == ST_RUN) || ((state == ST_WAIT) && clk_ready);

endmodule

// File: rtl/bors_checker.sv
module bors_checker (
  input logic clk,
  input logic rst_n,
  input logic bo_s,
  input logic clk_ready,
  input logic pwr_done,
  input logic core_rst,
  input logic clk_en,
  input logic rel_pulse,
  input logic bor_flag,
  input logic sw_wr,
  input logic sw_wdata
);
  AST_HOLD_ON_BO: assert property (@(posedge clk) disable iff (!rst_n)
    bo_s |=> (core_rst && !clk_en)); // R1

  AST_CLK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst && !clk_ready) |-> !clk_en); // R4

  AST_GATES_MET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> ($past(pwr_done) && $past(clk_ready))); // R5

  AST_REL_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> rel_pulse); // R9

  AST_REL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |=> !rel_pulse); // R9

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bo_s |=> bor_flag); // R8

  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_wdata && bor_flag) |=> bor_flag); // R8

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !sw_wdata && !bo_s) |=> !bor_flag); // R8
endmodule

bind bor_release_seq bors_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bo_s      (bo_s),
  .clk_ready (clk_ready),
  .pwr_done  (pwr_done),
  .core_rst  (core_rst),
  .clk_en    (clk_en),
  .rel_pulse (rel_pulse),
  .bor_flag  (bor_flag),
  .sw_wr     (sw_wr),
  .sw_wdata  (sw_wdata)
);

// File: tb/bor_release_seq_test.sv
`timescale 1ns/1ps
module bor_release_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bo_async = 1'b0;
  logic       pll_lock = 1'b1;
  logic [2:0] cfg_osc_sel = 3'b000;
  logic [1:0] cfg_posc_mode = 2'b00;
  logic [2:0] cfg_pwrt = 3'b000;
  logic       sw_wr = 1'b0;
  logic       sw_wdata = 1'b0;
  logic       core_rst, clk_en, rel_pulse, bor_flag;
  logic [2:0] clk_src;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  bor_release_seq uut (
    .clk(clk), .rst_n(rst_n), .bo_async(bo_async), .pll_lock(pll_lock),
    .cfg_osc_sel(cfg_osc_sel), .cfg_posc_mode(cfg_posc_mode), .cfg_pwrt(cfg_pwrt),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .core_rst(core_rst), .clk_en(clk_en),
    .rel_pulse(rel_pulse), .bor_flag(bor_flag), .clk_src(clk_src)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic [1:0]  posc;
    logic [2:0]  pwrt;
    logic [15:0] rel_edge;
    logic [31:0] req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 2'b00, 3'd0, 16'd4,   "R2"},
    '{3'b010, 2'b00, 3'd0, 16'd4,   "R2"},
    '{3'b010, 2'b01, 3'd0, 16'd16,  "R6"},
    '{3'b010, 2'b10, 3'd3, 16'd20,  "R5"},
    '{3'b001, 2'b00, 3'd1, 16'd8,   "R5"},
    '{3'b000, 2'b00, 3'd7, 16'd260, "R5"},
    '{3'b010, 2'b01, 3'd1, 16'd12,  "R3"},
    '{3'b100, 2'b01, 3'd2, 16'd12,  "R5"},
    '{3'b011, 2'b10, 3'd0, 16'd16,  "R6"}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sw_write(input logic v);
    sw_wr = 1'b1; sw_wdata = v;
    step(1);
    sw_wr = 1'b0; sw_wdata = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    // R11 reset state
    chk("R11", {31'd0, core_rst}, 32'd0);
    chk("R11", {31'd0, clk_en}, 32'd1);
    chk("R11", {31'd0, rel_pulse}, 32'd0);
    chk("R11", {31'd0, bor_flag}, 32'd0);
    chk("R11", {29'd0, clk_src}, 32'd0);
    rst_n = 1'b1;
    step(2);

    // table of release timings
    for (int v = 0; v < NV; v++) begin
      cfg_osc_sel   = VECS[v].sel;
      cfg_posc_mode = VECS[v].posc;
      cfg_pwrt      = VECS[v].pwrt;
      bo_async = 1'b1;
      step(5);
      chk("R1", {31'd0, core_rst}, 32'd1);
      chk("R1", {31'd0, clk_en}, 32'd0);
      chk("R8", {31'd0, bor_flag}, 32'd1);
      chk("R10", {29'd0, clk_src}, {29'd0, VECS[v].sel});
      bo_async = 1'b0;
      step(int'(VECS[v].rel_edge) - 1);
      chk(string'(VECS[v].req), {31'd0, core_rst}, 32'd1);
      step(1);
      chk(string'(VECS[v].req), {31'd0, core_rst}, 32'd0);
      chk("R9", {31'd0, rel_pulse}, 32'd1);
      chk("R2", {31'd0, clk_en}, 32'd1);
      step(1);
      chk("R9", {31'd0, rel_pulse}, 32'd0);
      sw_write(1'b0);
      chk("R8", {31'd0, bor_flag}, 32'd0);
    end

    // R1 onset latency
    cfg_osc_sel = 3'b000; cfg_posc_mode = 2'b00; cfg_pwrt = 3'd0;
    bo_async = 1'b1;
    step(2);
    chk("R1", {31'd0, core_rst}, 32'd0);
    chk("R1", {31'd0, clk_en}, 32'd1);
    step(1);
    chk("R1", {31'd0, core_rst}, 32'd1);
    // R8 write 1 no effect, clear loses to active brown-out
    sw_write(1'b1);
    chk("R8", {31'd0, bor_flag}, 32'd1);
    sw_write(1'b0);
    chk("R8", {31'd0, bor_flag}, 32'd1);
    bo_async = 1'b0;
    step(10);
    sw_write(1'b1);
    chk("R8", {31'd0, bor_flag}, 32'd1);
    sw_write(1'b0);
    chk("R8", {31'd0, bor_flag}, 32'd0);

    // R10 later config change ignored
    cfg_osc_sel = 3'b111;
    step(3);
    chk("R10", {29'd0, clk_src}, 32'd0);

    // R4 PLL lock gating
    cfg_osc_sel = 3'b001; cfg_posc_mode = 2'b00; cfg_pwrt = 3'd0;
    pll_lock = 1'b0;
    bo_async = 1'b1;
    step(5);
    bo_async = 1'b0;
    step(30);
    chk("R4", {31'd0, core_rst}, 32'd1);
    chk("R4", {31'd0, clk_en}, 32'd0);
    pll_lock = 1'b1;
    step(1);
    chk("R4", {31'd0, clk_en}, 32'd0);
    step(1);
    chk("R4", {31'd0, clk_en}, 32'd1);
    chk("R4", {31'd0, core_rst}, 32'd1);
    step(1);
    chk("R4", {31'd0, core_rst}, 32'd0);
    chk("R9", {31'd0, rel_pulse}, 32'd1);

    // R7 restart on a new brown-out during the wait
    cfg_osc_sel = 3'b000; cfg_pwrt = 3'd5;
    bo_async = 1'b1;
    step(5);
    bo_async = 1'b0;
    step(40);
    chk("R7", {31'd0, core_rst}, 32'd1);
    bo_async = 1'b1;
    step(4);
    bo_async = 1'b0;
    step(67);
    chk("R7", {31'd0, core_rst}, 32'd1);
    step(1);
    chk("R7", {31'd0, core_rst}, 32'd0);
    chk("R9", {31'd0, rel_pulse}, 32'd1);

    step(3);
    finish_run();
  end
endmodule